// File: doc/BRIEF.md
# Relational Compare Unit

This unit compares two operands of configurable width and reduces the comparison to one boolean answer. A three-bit function code picks which relation is tested. The relations cover equality, inequality, unsigned orderings and two's-complement signed orderings, and each one is written as "b relative to a". There is no registering inside the unit. The answer appears on an output bus as wide as the operands, as all ones or all zeros.

It is meant to sit in a datapath next to an adder or a shifter. The output can drive a branch decision or a mask, or it can be merged into a wider result word. The width is set by the parameter `WIDTH` (default 4, any value of 2 or more).

Top module: `relcmp_unit`

## Requirements
- R1: Function code 3'b000 yields true exactly when opnd_b equals opnd_a.
- R2: Function code 3'b001 yields true exactly when opnd_b differs from opnd_a.
- R3: Function code 3'b010 yields true exactly when opnd_b is below opnd_a, both read as unsigned.
- R4: Function code 3'b011 yields true exactly when opnd_b is above opnd_a, both read as unsigned.
- R5: Function code 3'b100 yields true exactly when opnd_b is at or below opnd_a, both read as unsigned.
- R6: Function code 3'b101 yields true exactly when opnd_b is below opnd_a, both read as two's-complement signed.
- R7: Function code 3'b110 yields true exactly when opnd_b is above opnd_a, both read as two's-complement signed.
- R8: Function code 3'b111 yields true exactly when opnd_b is at or below opnd_a, both read as two's-complement signed.
- R9: True is driven as every bit of res_y set, and false as every bit of res_y clear. No other pattern ever appears.
- R10: res_y is a pure function of the present inputs. A change on any input is reflected without any clock edge.
- R11: A set most significant bit marks a negative value only for codes 3'b101 to 3'b111. For WIDTH 4, 4'b1000 is below 4'b0111 as signed and above it as unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | Reference operand (right-hand side of the relation) |
| opnd_b | input | WIDTH | Tested operand (left-hand side of the relation) |
| func_sel | input | 3 | Relation selector |
| res_y | output | WIDTH | Result, all ones for true and all zeros for false |

## Verification
The checks bound to the unit assume that all three inputs carry known values and have settled when they are evaluated. Under that assumption they judge only the shape of res_y and the relations whose answer follows directly from equal operands or from differing sign bits. The stimulus therefore changes the inputs only on one clock edge and reads the result at the opposite edge, and it never drives X or Z. It walks every operand pair under every function code, which covers zero, all ones, the most negative value and the most positive value.

// File: rtl/relcmp_pkg.sv
package relcmp_pkg;
  typedef enum logic [2:0] {
    FN_EQ  = 3'b000,
    FN_NE  = 3'b001,
    FN_ULT = 3'b010,
    FN_UGT = 3'b011,
    FN_ULE = 3'b100,
    FN_SLT = 3'b101,
    FN_SGT = 3'b110,
    FN_SLE = 3'b111
  } relcmp_fn_e;

  typedef struct packed {
    logic eq;
    logic ult;
    logic ugt;
    logic slt;
    logic sgt;
  } relcmp_flags_t;
endpackage

// File: rtl/relcmp_eq.sv
module relcmp_eq #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic             same
);
  logic [WIDTH-1:0] diff_bits;

  always_comb begin
    diff_bits = lhs ^ rhs;
    same      = ~|diff_bits;
  end
endmodule

// File: rtl/relcmp_mag.sv
module relcmp_mag #(
  parameter int WIDTH     = 4,
  parameter bit TWOS_COMP = 1'b0
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic             lhs_below,
  output logic             lhs_above
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] lhs_k;
  logic [WIDTH-1:0] rhs_k;

  // Flipping the sign bit maps two's-complement order onto unsigned order.
  generate
    if (TWOS_COMP) begin : g_signed
      always_comb begin
        lhs_k = {~lhs[MSB], lhs[MSB-1:0]};
        rhs_k = {~rhs[MSB], rhs[MSB-1:0]};
      end
    end else begin : g_unsigned
      always_comb begin
        lhs_k = lhs;
        rhs_k = rhs;
      end
    end
  endgenerate

  always_comb begin
    lhs_below = (lhs_k < rhs_k);
    lhs_above = (lhs_k > rhs_k);
  end
endmodule

// File: rtl/relcmp_sel.sv
module relcmp_sel
  import relcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  relcmp_flags_t    flags,
  input  logic [2:0]       fn,
  output logic [WIDTH-1:0] bus
);
  logic verdict;

  always_comb begin
    unique case (relcmp_fn_e'(fn))
      FN_EQ:   verdict = flags.eq;
      FN_NE:   verdict = ~flags.eq;
      FN_ULT:  verdict = flags.ult;
      FN_UGT:  verdict = flags.ugt;
      FN_ULE:  verdict = ~flags.ugt;
      FN_SLT:  verdict = flags.slt;
      FN_SGT:  verdict = flags.sgt;
      FN_SLE:  verdict = ~flags.sgt;
      default: verdict = 1'b0;
    endcase
    bus = {WIDTH{verdict}};
  end
endmodule

// File: rtl/relcmp_unit.sv
module relcmp_unit
  import relcmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [2:0]       func_sel,
  output logic [WIDTH-1:0] res_y
);
  relcmp_flags_t flags;

  relcmp_eq #(.WIDTH(WIDTH)) u_eq (
    .lhs  (opnd_b),
    .rhs  (opnd_a),
    .same (flags.eq)
  );

  relcmp_mag #(.WIDTH(WIDTH), .TWOS_COMP(1'b0)) u_mag_u (
    .lhs       (opnd_b),
    .rhs       (opnd_a),
    .lhs_below (flags.ult),
    .lhs_above (flags.ugt)
  );

  relcmp_mag #(.WIDTH(WIDTH), .TWOS_COMP(1'b1)) u_mag_s (
    .lhs       (opnd_b),
    .rhs       (opnd_a),
    .lhs_below (flags.slt),
    .lhs_above (flags.sgt)
  );

  relcmp_sel #(.WIDTH(WIDTH)) u_sel (
    .flags (flags),
    .fn    (func_sel),
    .bus   (res_y)
  );
endmodule

// File: rtl/relcmp_unit_chk.sv
module relcmp_unit_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [2:0]       func_sel,
  input logic [WIDTH-1:0] res_y
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    AST_Y_UNIFORM: assert (res_y == '0 || res_y == '1); // R9
    if (func_sel == 3'b000 && opnd_a != opnd_b)
      AST_EQ_MISS: assert (res_y == '0); // R1
    if (func_sel == 3'b001 && opnd_a == opnd_b)
      AST_NE_SAME: assert (res_y == '0); // R2
    if ((func_sel == 3'b010 || func_sel == 3'b101) && opnd_a == opnd_b)
      AST_LT_STRICT: assert (res_y == '0); // R3
    if ((func_sel == 3'b011 || func_sel == 3'b110) && opnd_a == opnd_b)
      AST_GT_STRICT: assert (res_y == '0); // R7
    if ((func_sel == 3'b100 || func_sel == 3'b111) && opnd_a == opnd_b)
      AST_LE_INCLUSIVE: assert (res_y == '1); // R5
    if (func_sel == 3'b011 && opnd_b[MSB] && !opnd_a[MSB])
      AST_UNS_TOPBIT: assert (res_y == '1); // R4
    if (func_sel == 3'b101 && opnd_b[MSB] && !opnd_a[MSB])
      AST_SGN_NEGATIVE: assert (res_y == '1); // R6
    if (func_sel == 3'b111 && !opnd_b[MSB] && opnd_a[MSB])
      AST_SGN_LE_POS: assert (res_y == '0); // R8
  end
endmodule

bind relcmp_unit relcmp_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .func_sel (func_sel),
  .res_y    (res_y)
);

// File: tb/relcmp_unit_tb_top.sv
module relcmp_unit_tb_top;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic [2:0]   fs_in;
  logic [W-1:0] y_out;

  int compared;
  int mismatched;
  bit done;
  item_t exp_q[$];

  relcmp_unit #(.WIDTH(W)) dut_i (
    .opnd_a   (a_in),
    .opnd_b   (b_in),
    .func_sel (fs_in),
    .res_y    (y_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int as_signed(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - SPAN : int'(v);
  endfunction

  function automatic bit model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    int ua = int'(a), ub = int'(b);
    int sa = as_signed(a), sb = as_signed(b);
    case (f)
      3'd0: return ub == ua;
      3'd1: return ub != ua;
      3'd2: return ub < ua;
      3'd3: return ub > ua;
      3'd4: return ub <= ua;
      3'd5: return sb < sa;
      3'd6: return sb > sa;
      default: return sb <= sa;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Driver: drive on a rising edge, queue the expected value.
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2:0] f, input string tag);
    item_t it;
    @(posedge clk);
    a_in  = a;
    b_in  = b;
    fs_in = f;
    it.exp = model(a, b, f) ? '1 : '0;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: compare on the falling edge after each drive.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      compared++;
      if (y_out !== it.exp) begin
        mismatched++;
        $display("FAIL %s a=%b b=%b sel=%b actual=%b expected=%b",
                 it.tag, a_in, b_in, fs_in, y_out, it.exp);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    compared   = 0;
    mismatched = 0;
    done       = 1'b0;
    a_in  = '0;
    b_in  = '0;
    fs_in = 3'b000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero inputs under equality give all ones (R1, R9).
    drive('0, '0, 3'b000, "R9_reset_R1");

    // R11 signed versus unsigned corner: b=1000, a=0111.
    drive(4'b0111, 4'b1000, 3'b010, "R11_ult");
    drive(4'b0111, 4'b1000, 3'b011, "R11_ugt");
    drive(4'b0111, 4'b1000, 3'b101, "R11_slt");
    drive(4'b0111, 4'b1000, 3'b110, "R11_sgt");
    drive(4'b0111, 4'b1000, 3'b111, "R11_sle");
    drive(4'b1000, 4'b0111, 3'b100, "R11_ule");

    // Corner operand set under every code (R1..R8 via req_of).
    for (int f = 0; f < 8; f++) begin
      logic [W-1:0] corners [4];
      corners[0] = '0;
      corners[1] = '1;
      corners[2] = {1'b1, {(W-1){1'b0}}};
      corners[3] = {1'b0, {(W-1){1'b1}}};
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(corners[i], corners[j], 3'(f), {req_of(3'(f)), "_corner"});
    end

    // R10: only func_sel changes between consecutive cycles, result follows at once.
    drive(4'b0011, 4'b0101, 3'b010, "R10_hold");
    drive(4'b0011, 4'b0101, 3'b011, "R10_follow");

    // Exhaustive sweep of every operand pair and code.
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++)
          drive(W'(a), W'(b), 3'(f), req_of(3'(f)));

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule